// File: doc/BRIEF.md
# Chip-Select Region Address Decoder

This block keeps one configuration word for each of eight external chip selects and uses them to steer incoming 32-bit system addresses. Each word holds a region base, a size code and an enable flag. The block compares every address against all enabled, well-formed regions. It returns a one-hot select for the winning region, a hit flag, and the byte offset of the address inside that region.

A region is a naturally aligned window of 16, 32, 64 or 128 MiB inside the low 1 GiB of the address space. A size code outside the allowed set makes the chip select misconfigured, and so does a base that is not aligned to its window. A misconfigured chip select reports an error bit and is left out of decoding. When several regions claim the same address, the lowest-numbered chip select wins and an overlap flag is raised.

Configuration words are written through a simple write port that selects one chip select at a time. They are read back through a separate combinational read port.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset, the word of chip select 0 reads 0xF40 and every other word reads 0xF00. In a word, bits 5:0 hold the base, bit 6 is the enable and bits 11:8 hold the size code. Chip select 0 therefore decodes 0x0000000–0x0FFFFFF after reset.
- R2: A write stores only the data bits under 0xF7F. Bit 7 and bits 31:12 always read back as zero.
- R3: The only legal size codes are 0x8, 0xC, 0xE and 0xF. An enabled chip select with any other code drives its cs_err bit high.
- R4: An enabled chip select drives its cs_err bit high when any of base bits 3:0 is set at a position where the size code bit is clear.
- R5: A chip select whose enable bit is clear never matches and never raises cs_err.
- R6: An enabled, legal chip select matches when addr[29:0] lies in [base·2^24, base·2^24 + size). Here size = (0x0FFFFFFF with the code shifted to bits 27:24 cleared) + 1. Address bits 31:30 are ignored.
- R7: cs_sel is one-hot on the lowest-numbered matching chip select and zero when nothing matches. cs_hit equals the OR of cs_sel.
- R8: cs_overlap is high exactly when two or more chip selects match the current address.
- R9: cs_offset equals addr[29:0] minus the winning region's start when cs_hit is high, and zero otherwise.
- R10: cs_err follows the stored word. It stays high until a later write makes the word legal or clears its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Chip select addressed by the write |
| cfg_wdata | input | 32 | Write data |
| rd_sel | input | 3 | Chip select shown on rd_data |
| rd_data | output | 32 | Stored configuration word |
| addr | input | 32 | System address to decode |
| cs_sel | output | 8 | One-hot winning chip select |
| cs_hit | output | 1 | Some chip select matched |
| cs_overlap | output | 1 | Two or more chip selects matched |
| cs_offset | output | 27 | Offset inside the winning region |
| cs_err | output | 8 | Per-chip-select misconfiguration |

## Verification
Priority resolution and overlap detection act on the same address, so both happen in the same evaluation. The bench provokes this by enabling nested and coincident regions on chip selects 0, 2 and 5. It then walks addresses through the shared and the private parts of those windows, and checks the select, the flag and the offset against an arithmetic interval model. Misconfiguration and decoding also coincide: a full sweep of all 16 size codes against all 64 bases checks, for each address, that an erroneous chip select never wins.

// File: rtl/cs_region_decoder.sv
module cs_region_decoder #(
  parameter int NCS   = 8,
  parameter int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data,
  input  logic [31:0]      addr,
  output logic [NCS-1:0]   cs_sel,
  output logic             cs_hit,
  output logic             cs_overlap,
  output logic [26:0]      cs_offset,
  output logic [NCS-1:0]   cs_err
);
  localparam logic [11:0] KEEP = 12'hF7F;

  logic [11:0]    word [NCS];
  logic [NCS-1:0] raw;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic [5:0] base;
    logic [3:0] code;
    logic       en, code_ok, base_ok;

    always_ff @(posedge clk) begin
      if (!rst_n)
        word[g] <= (g == 0) ? 12'hF40 : 12'hF00;
      else if (cfg_we && cfg_sel == SEL_W'(g))
        word[g] <= cfg_wdata[11:0] & KEEP;
    end

    assign base    = word[g][5:0];
    assign en      = word[g][6];
    assign code    = word[g][11:8];
    assign code_ok = (code == 4'h8) || (code == 4'hC) || (code == 4'hE) || (code == 4'hF);
    assign base_ok = (base[3:0] & ~code) == 4'h0;
    assign cs_err[g] = en && !(code_ok && base_ok);
    assign raw[g] = en && code_ok && base_ok &&
                    (((addr[29:24] ^ base) & {2'b11, code}) == 6'h00);
  end

  assign cs_sel     = raw & (~raw + NCS'(1));
  assign cs_hit     = |raw;
  assign cs_overlap = (raw & (raw - NCS'(1))) != '0;

  logic [3:0] win_code;
  always_comb begin
    win_code = 4'hF;
    for (int i = NCS - 1; i >= 0; i--)
      if (raw[i]) win_code = word[i][11:8];
  end

  assign cs_offset = cs_hit ? {addr[26:24] & ~win_code[2:0], addr[23:0]} : 27'h0;
  assign rd_data   = {20'h0, word[rd_sel]};
endmodule

module cs_region_decoder_chk #(
  parameter int NCS   = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [31:0]      cfg_wdata,
  input logic [SEL_W-1:0] rd_sel,
  input logic [31:0]      rd_data,
  input logic [NCS-1:0]   cs_sel,
  input logic             cs_hit,
  input logic             cs_overlap,
  input logic [26:0]      cs_offset,
  input logic [NCS-1:0]   cs_err
);
  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));
  assert_hit_matches_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hit == (cs_sel != '0));
  assert_err_never_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel & cs_err) == '0);
  assert_overlap_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_overlap |-> cs_hit);
  assert_offset_zero_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hit |-> cs_offset == 27'h0);
  assert_write_kept_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && rd_sel == $past(cfg_sel)) |-> rd_data == ($past(cfg_wdata) & 32'hF7F));
  assert_readback_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:12] == 20'h0 && !rd_data[7]);
endmodule

bind cs_region_decoder cs_region_decoder_chk #(.NCS(NCS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .rd_sel(rd_sel), .rd_data(rd_data), .cs_sel(cs_sel), .cs_hit(cs_hit),
  .cs_overlap(cs_overlap), .cs_offset(cs_offset), .cs_err(cs_err)
);

// File: tb/test_cs_region_decoder.sv
module test_cs_region_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [31:0] addr = '0;
  logic [7:0]  cs_sel;
  logic        cs_hit;
  logic        cs_overlap;
  logic [26:0] cs_offset;
  logic [7:0]  cs_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [11:0] mdl [NCS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_region_decoder i_cs_region_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .addr(addr), .cs_sel(cs_sel), .cs_hit(cs_hit),
    .cs_overlap(cs_overlap), .cs_offset(cs_offset), .cs_err(cs_err)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic wr(input int cs, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(cs); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[cs] = data[11:0] & 12'hF7F;
  endtask

  function automatic bit legal(input logic [11:0] w);
    logic [3:0] c;
    c = w[11:8];
    return (c == 4'h8 || c == 4'hC || c == 4'hE || c == 4'hF) && ((w[3:0] & ~c) == 4'h0);
  endfunction

  task automatic check_addr(input logic [31:0] a);
    logic [7:0]  e_sel, e_err;
    logic [26:0] e_off;
    int          nmatch;
    addr = a;
    #1;
    e_sel = '0; e_err = '0; e_off = '0; nmatch = 0;
    for (int i = 0; i < NCS; i++) begin
      longint start, size, a30;
      if (mdl[i][6] && !legal(mdl[i])) e_err[i] = 1'b1;
      start = longint'(mdl[i][5:0]) * 64'h0100_0000;
      size  = longint'((32'h0FFF_FFFF & ~(32'(mdl[i][11:8]) << 24)) + 1);
      a30   = longint'(a & 32'h3FFF_FFFF);
      if (mdl[i][6] && legal(mdl[i]) && a30 >= start && a30 < start + size) begin
        if (nmatch == 0) begin
          e_sel[i] = 1'b1;
          e_off = 27'(a30 - start);
        end
        nmatch++;
      end
    end
    cmp("R3/R4/R5/R10 err", 32'(cs_err), 32'(e_err));
    cmp("R6/R7 sel", 32'(cs_sel), 32'(e_sel));
    cmp("R7 hit", 32'(cs_hit), 32'(nmatch > 0));
    cmp("R8 overlap", 32'(cs_overlap), 32'(nmatch > 1));
    cmp("R9 offset", 32'(cs_offset), 32'(e_off));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCS; i++) mdl[i] = (i == 0) ? 12'hF40 : 12'hF00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset words and reset decode
    for (int i = 0; i < NCS; i++) begin
      rd_sel = 3'(i); #1;
      cmp("R1 reset word", rd_data, (i == 0) ? 32'hF40 : 32'hF00);
    end
    check_addr(32'h0000_1234);
    check_addr(32'hC0FF_FFFF);
    check_addr(32'h0100_0000);

    // R2 write masking
    wr(4, 32'hFFFF_FFFF);
    rd_sel = 3'd4; #1;
    cmp("R2 kept bits", rd_data, 32'h0000_0F7F);
    wr(4, 32'h0000_0000);
    rd_sel = 3'd4; #1;
    cmp("R2 cleared", rd_data, 32'h0);

    // R3 R4 R6 R9 sweep every code and base on chip select 3, others off
    wr(0, 32'h0);
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 64; b++) begin
        wr(3, 32'h40 | (c << 8) | b);
        for (int t = 0; t < 64; t++) begin
          check_addr({2'b00, 6'(t), 24'h5A_5A5A});
          check_addr({2'b11, 6'(t), 24'hFF_FFFF});
        end
      end

    // R5 invalid but misconfigured: no error, no match
    wr(3, 32'h0000_0305);
    check_addr(32'h0500_0000);
    // R10 error holds, then clears on legal write
    wr(3, 32'h0000_0345);
    repeat (3) @(negedge clk);
    check_addr(32'h0500_0000);
    wr(3, 32'h0000_0F45);
    check_addr(32'h0500_0000);
    wr(3, 32'h0);

    // R7 R8 overlap priority: nested and coincident regions
    wr(0, 32'h0000_0C54);
    wr(2, 32'h0000_0850);
    wr(5, 32'h0000_0F56);
    for (int t = 0; t < 64; t++) begin
      check_addr({2'b01, 6'(t), 24'h00_0000});
      check_addr({2'b00, 6'(t), 24'h12_3456});
    end
    wr(0, 32'h0);
    for (int t = 16; t < 32; t++) check_addr({2'b00, 6'(t), 24'hAB_CDEF});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule